// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the oversampling tick of a serial receiver and transmitter from the system clock. Software computes a divisor and loads it through a one-cycle load strobe. The divisor has an 18-bit whole part, counted in system clocks, and a 6-bit fraction, counted in sixty-fourths of a clock. The whole part is the system clock frequency divided by the baud rate times the oversampling factor, truncated. The fraction is the remainder of that division, scaled by 64 and rounded to nearest. The block turns this divisor into a stream of single-cycle ticks. Over a long run, their average spacing equals the whole part plus the fraction.

The fraction is applied by dithering. After every tick, the fraction is added into a 6-bit phase accumulator. When that addition carries out, the next tick period is one clock longer. A mode bit, loaded with the divisor, selects 16 ticks per bit (mode bit clear) or 8 ticks per bit (mode bit set). A second output, the bit strobe, pulses together with every 16th or 8th tick. Loading a divisor or dropping the enable restarts the period counter, the phase accumulator and the tick count of the bit strobe. A whole part of zero halts the tick output.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `os_tick` and `bit_strobe` are low and the stored divisor is zero, so asserting `en` without any load produces no tick.
- R2: With fraction 0 and whole part W ≥ 1, the first tick appears W clocks after the restart. Every later tick follows W clocks after the one before it, and each tick lasts one cycle.
- R3: With whole part W and fraction F (0..63), the k-th tick after a restart appears k·W + floor((k−1)·F/64) clocks after the restart. Clock 1 is the first rising edge with `en` high and no load.
- R4: Every interval between two consecutive ticks with no restart between them is either W or W+1 clocks long.
- R5: While the stored whole part is zero, `os_tick` and `bit_strobe` stay low.
- R6: While `en` is low, no tick or strobe is produced. Raising `en` again restarts the period, the fraction phase and the strobe count, so the tick timing again follows R3 with k counted from 1.
- R7: A load, whether `en` is high or low, stores `cfg_whole`, `cfg_frac` and `cfg_x8` and restarts the tick timing and strobe count per R3 from the clock after the load.
- R8: With `cfg_x8` = 0 stored, `bit_strobe` is high on ticks 16, 32, 48 and so on after a restart, and is low otherwise.
- R9: With `cfg_x8` = 1 stored, `bit_strobe` is high on ticks 8, 16, 24 and so on after a restart, and is low otherwise.
- R10: `bit_strobe` is never high in a cycle where `os_tick` is low.
- R11: With whole part 1 and fraction 0, `os_tick` is high in every cycle. With whole part 1 and a nonzero fraction, a single low cycle is inserted after each carry of the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator idle and restarts it |
| cfg_load | input | 1 | One-cycle strobe that stores the divisor and mode bit |
| cfg_whole | input | INT_W (18) | Whole part of the divisor in clocks |
| cfg_frac | input | FRAC_W (6) | Fraction of the divisor in 1/64 clock |
| cfg_x8 | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 ticks per bit |
| os_tick | output | 1 | Single-cycle oversampling tick |
| bit_strobe | output | 1 | Pulse on every 8th or 16th tick, coincident with the tick |

## Verification
The tick and the bit strobe share a cycle by design, so the pairing is checked on every tick of every run. The sweeps extend past the 16th and 32nd ticks under both modes. The expected strobe positions are counted from the restart, independently of the tick timing formula. The second coincidence is a divisor load that arrives while a tick is due and the strobe count is part-way through its cycle. That case is provoked by reloading a running generator after ten ticks. It is judged by requiring the next ticks to follow R3 from the new divisor and the first strobe to land on the 16th post-load tick.

// File: rtl/frac_baud_pkg.sv
// Shared constants and types for the fractional baud tick generator.
// Assumes the oversampling ratios are powers of two.
package frac_baud_pkg;
    localparam int DEF_INT_W  = 18;
    localparam int DEF_FRAC_W = 6;
    localparam int OVS_HI     = 16;
    localparam int OVS_LO     = 8;
    localparam int STB_W      = $clog2(OVS_HI);

    typedef enum logic {
        OVS_X16 = 1'b0,
        OVS_X8  = 1'b1
    } ovs_mode_e;
endpackage

// File: rtl/fbg_div_reg.sv
// Holds the divisor and the oversampling mode captured on a load strobe.
// Assumes the load strobe is a single cycle; the fields are stored as given.
module fbg_div_reg
    import frac_baud_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  whole_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              x8_in,
    output logic [INT_W-1:0]  whole_q,
    output logic [FRAC_W-1:0] frac_q,
    output ovs_mode_e         mode_q
);
    // Capture the divisor fields; reset clears them to a halted divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole_q <= '0;
            frac_q  <= '0;
            mode_q  <= OVS_X16;
        end else if (load) begin
            whole_q <= whole_in;
            frac_q  <= frac_in;
            mode_q  <= ovs_mode_e'(x8_in);
        end
    end
endmodule

// File: rtl/fbg_period_ctr.sv
// Counts clocks between ticks. The period is the whole part plus one extra
// clock when the previous tick's phase addition carried out. Exposes the
// pre-register hit so the strobe counter can align with the tick.
// Assumes restart is asserted on any load or loss of enable.
module fbg_period_ctr
    import frac_baud_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [INT_W-1:0]  whole,
    input  logic [FRAC_W-1:0] frac,
    output logic              hit,
    output logic              tick
);
    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  period;
    logic [FRAC_W-1:0] phase_q;
    logic              stretch_q;
    logic              halted;
    logic [FRAC_W:0]   phase_sum;

    // Current period target and halt condition.
    always_comb begin
        halted    = (whole == '0);
        period    = {1'b0, whole} + CNT_W'(stretch_q);
        phase_sum = {1'b0, phase_q} + {1'b0, frac};
        hit       = !restart && !halted && ((cnt_q + 1'b1) == period);
    end

    // Advance the counter and phase, and register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || halted) begin
            cnt_q     <= '0;
            phase_q   <= '0;
            stretch_q <= 1'b0;
            tick      <= 1'b0;
        end else begin
            tick <= hit;
            if (hit) begin
                cnt_q     <= '0;
                phase_q   <= phase_sum[FRAC_W-1:0];
                stretch_q <= phase_sum[FRAC_W];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbg_bit_strobe.sv
// Counts ticks and raises the bit strobe on the last tick of each bit,
// registered on the same edge as the tick itself.
// Assumes hit is the pre-register form of the tick.
module fbg_bit_strobe
    import frac_baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      hit,
    input  ovs_mode_e mode,
    output logic      strobe
);
    logic [STB_W-1:0] tcnt_q;
    logic [STB_W-1:0] last;

    // Last tick index for the selected ratio.
    always_comb begin
        last = (mode == OVS_X8) ? STB_W'(OVS_LO - 1) : STB_W'(OVS_HI - 1);
    end

    // Count ticks, wrap on the last one and pulse the strobe there.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tcnt_q <= '0;
            strobe <= 1'b0;
        end else if (hit) begin
            strobe <= (tcnt_q == last);
            tcnt_q <= (tcnt_q == last) ? '0 : tcnt_q + 1'b1;
        end else begin
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Top of the fractional baud tick generator: divisor register, dithered
// period counter and bit strobe counter. Assumes the divisor is computed by
// software and that a load is a single-cycle strobe.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_load,
    input  logic [INT_W-1:0]  cfg_whole,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cfg_x8,
    output logic              os_tick,
    output logic              bit_strobe
);
    logic [INT_W-1:0]  whole_q;
    logic [FRAC_W-1:0] frac_q;
    ovs_mode_e         mode_q;
    logic              restart;
    logic              hit;

    // Any load or loss of enable restarts the timing.
    always_comb begin
        restart = cfg_load || !en;
    end

    fbg_div_reg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .whole_in (cfg_whole),
        .frac_in  (cfg_frac),
        .x8_in    (cfg_x8),
        .whole_q  (whole_q),
        .frac_q   (frac_q),
        .mode_q   (mode_q)
    );

    fbg_period_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .whole   (whole_q),
        .frac    (frac_q),
        .hit     (hit),
        .tick    (os_tick)
    );

    fbg_bit_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .hit     (hit),
        .mode    (mode_q),
        .strobe  (bit_strobe)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
// Property checker for the fractional baud tick generator, bound to the top.
// Keeps its own interval and tick counters instead of reading the design's.
module frac_baud_gen_chk
    import frac_baud_pkg::*;
#(
    parameter int INT_W = DEF_INT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cfg_load,
    input logic             os_tick,
    input logic             bit_strobe,
    input logic [INT_W-1:0] whole_q,
    input ovs_mode_e        mode_q
);
    logic             rs;
    logic [INT_W:0]   gap_q;
    logic             seen_q;
    logic [STB_W-1:0] ticks_q;

    always_comb rs = cfg_load || !en;

    // Measure clocks since the last tick and ticks since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || rs) begin
            gap_q   <= '0;
            seen_q  <= 1'b0;
            ticks_q <= '0;
        end else begin
            if (os_tick) begin
                gap_q   <= (INT_W+1)'(1);
                seen_q  <= 1'b1;
                ticks_q <= bit_strobe ? '0 : ticks_q + 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_strobe_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> os_tick);

    assert_quiet_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!os_tick && !bit_strobe));

    assert_load_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !os_tick);

    assert_zero_divisor_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (whole_q == '0) |-> (!os_tick && !bit_strobe));

    assert_interval_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && seen_q) |-> (gap_q == {1'b0, whole_q} || gap_q == {1'b0, whole_q} + 1'b1));

    assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (ticks_q == ((mode_q == OVS_X8) ? STB_W'(OVS_LO - 1) : STB_W'(OVS_HI - 1))));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_load   (cfg_load),
    .os_tick    (os_tick),
    .bit_strobe (bit_strobe),
    .whole_q    (whole_q),
    .mode_q     (mode_q)
);

// File: tb/frac_baud_gen_tb.sv
// Sweeps divisors and modes; expected tick and strobe positions are computed
// arithmetically from the requirement formulas.
module frac_baud_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W      = 18;
    localparam int FRAC_W     = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              en;
    logic              cfg_load;
    logic [INT_W-1:0]  cfg_whole;
    logic [FRAC_W-1:0] cfg_frac;
    logic              cfg_x8;
    logic              os_tick;
    logic              bit_strobe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cfg_load   (cfg_load),
        .cfg_whole  (cfg_whole),
        .cfg_frac   (cfg_frac),
        .cfg_x8     (cfg_x8),
        .os_tick    (os_tick),
        .bit_strobe (bit_strobe)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Store a divisor while idle, then enable; the next rising edge is clock 1.
    task automatic load_idle(input int w, input int f, input bit x8);
        @(negedge clk);
        en = 1'b0; cfg_load = 1'b1;
        cfg_whole = INT_W'(w); cfg_frac = FRAC_W'(f); cfg_x8 = x8;
        @(negedge clk);
        cfg_load = 1'b0; en = 1'b1;
    endtask

    // Store a divisor while running.
    task automatic load_live(input int w, input int f, input bit x8);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_whole = INT_W'(w); cfg_frac = FRAC_W'(f); cfg_x8 = x8;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Follow nt ticks from a restart, comparing each cycle to the formula.
    task automatic observe(input int w, input int f, input bit x8, input int nt, input string ttag);
        int k = 1;
        int ratio = x8 ? 8 : 16;
        int last_edge = nt * w + ((nt - 1) * f) / 64;
        int tick_err = 0, stb_err = 0, gap_err = 0, r10_err = 0;
        int prev = 0;
        int first_act = -1, first_exp = -1;
        string stag = x8 ? "R9" : "R8";
        for (int e = 1; e <= last_edge; e++) begin
            bit exp_t;
            bit exp_s;
            @(posedge clk);
            #1;
            exp_t = (e == k * w + ((k - 1) * f) / 64);
            exp_s = exp_t && ((k % ratio) == 0);
            if (os_tick !== exp_t) begin
                if (tick_err == 0) begin first_act = int'(os_tick); first_exp = int'(exp_t); end
                tick_err++;
            end
            if (bit_strobe !== exp_s) stb_err++;
            if (bit_strobe && !os_tick) r10_err++;
            if (os_tick) begin
                if (prev != 0 && (e - prev != w) && (e - prev != w + 1)) gap_err++;
                prev = e;
            end
            if (exp_t) k++;
        end
        checks++;
        if (tick_err != 0) begin
            fails++;
            $display("FAIL %s tick w=%0d f=%0d: actual %0d expected %0d (%0d bad cycles)",
                     ttag, w, f, first_act, first_exp, tick_err);
        end
        check(stag, stb_err, 0, "strobe mismatches");
        check("R4", gap_err, 0, "intervals outside W..W+1");
        check("R10", r10_err, 0, "strobe without tick");
    endtask

    initial begin
        int ws[4] = '{1, 2, 3, 5};
        int fs[5] = '{0, 1, 17, 32, 63};
        int cnt;
        rst_n = 1'b0; en = 1'b0; cfg_load = 1'b0;
        cfg_whole = '0; cfg_frac = '0; cfg_x8 = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1", int'(os_tick), 0, "tick after reset");
        check("R1", int'(bit_strobe), 0, "strobe after reset");

        // R1: enable without any load, stored divisor is zero
        en = 1'b1;
        cnt = 0;
        repeat (40) begin @(negedge clk); cnt += int'(os_tick); end
        check("R1", cnt, 0, "ticks with reset divisor");

        // R2, R3, R8, R9, R11: sweep
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 5; j++) begin
                    string tg = (ws[i] == 1) ? "R11" : ((fs[j] == 0) ? "R2" : "R3");
                    load_idle(ws[i], fs[j], m[0]);
                    observe(ws[i], fs[j], m[0], 34, tg);
                end
            end
        end

        // R5: zero whole part with a nonzero fraction
        load_idle(0, 5, 1'b0);
        cnt = 0;
        repeat (100) begin @(negedge clk); cnt += int'(os_tick) + int'(bit_strobe); end
        check("R5", cnt, 0, "ticks with zero divisor");

        // R6: disable mid-run, then re-enable from a fresh phase
        load_idle(3, 20, 1'b0);
        observe(3, 20, 1'b0, 10, "R3");
        @(negedge clk);
        en = 1'b0;
        cnt = 0;
        repeat (15) begin @(negedge clk); cnt += int'(os_tick) + int'(bit_strobe); end
        check("R6", cnt, 0, "ticks while disabled");
        en = 1'b1;
        observe(3, 20, 1'b0, 20, "R6");

        // R7: reload while running, part-way through a strobe count
        load_idle(2, 0, 1'b0);
        observe(2, 0, 1'b0, 10, "R2");
        load_live(3, 20, 1'b0);
        observe(3, 20, 1'b0, 33, "R7");
        load_live(4, 45, 1'b1);
        observe(4, 45, 1'b1, 17, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule